// File: doc/BRIEF.md
# Buffered 16-bit Compare Channel with Byte-Wide Access

This block is one compare channel of a 16-bit timer. The counter itself sits outside the block. The block receives the counter value along with one-cycle strobes that mark the TOP and BOTTOM turning points of the count. On every clock it checks the counter against an active compare value and raises a sticky match flag. An enable bit gates that flag onto an interrupt request line.

Software reaches the channel over an 8-bit bus. A single high-byte holding latch is shared by all 16-bit registers of the timer, so that 16-bit values move as one unit:
- **Writes:** the high byte is written first and parked in the latch. The low-byte write then commits both halves in one clock.
- **Counter reads:** reading the counter's low byte snapshots its high byte into the same latch.

The operating mode decides where compare writes land:
- **Non-PWM modes:** writes go straight to the active compare value.
- **PWM modes:** writes go to a shadow register. The active value takes the shadow's contents only at the selected turning point (TOP or BOTTOM), so a period never sees a half-updated threshold.

Top module: `oc_compare_unit`

## Requirements
- R1: When `cnt_i` equals the active compare value (`cmp_o`) at a rising clock edge, `flag_o` is 1 from that edge on.
- R2: Writing the control register (address 4) with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag unchanged. A match in the same cycle as a clear wins, and the flag stays 1.
- R3: A one-cycle pulse on `irq_ack_i` clears the flag, unless a match happens in that same cycle.
- R4: `irq_o` is 1 exactly when the flag is 1 and the enable bit is 1. The enable bit is bit 1 of address 4, and it is 0 after reset.
- R5: A write to address 1 or address 3 stores the data byte in the shared high-byte latch only. Neither the shadow value nor `cmp_o` changes.
- R6: In modes 0 (normal) and 1 (clear on match), a write of byte L to address 2 sets `cmp_o` to {latch, L} at the write's clock edge.
- R7: In modes 2 (single-slope PWM) and 3 (dual-slope PWM), a write to address 2 updates only the shadow value. `cmp_o` holds until a commit.
- R8: In the PWM modes, `cmp_o` takes the shadow value at the edge where `cnt_bot_i` is 1 when `commit_at_top_i` is 0. It takes it where `cnt_top_i` is 1 when `commit_at_top_i` is 1. The other strobe has no effect.
- R9: A read of address 0 returns `cnt_i[7:0]` and loads `cnt_i[15:8]` into the latch at that clock edge. A read of address 1 returns the latch.
- R10: The latch is shared. A low-byte compare write uses whatever the latch last received, whether that came from a high-byte write to either address or from a counter low-byte read.
- R11: After reset, the flag, the enable bit, the latch, the shadow value and `cmp_o` are all 0.
- R12: Reads of address 2 and address 3 return the low and high bytes of the shadow value. Read data is combinational from `bus_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Current counter value |
| cnt_top_i | input | 1 | Counter is at TOP this cycle |
| cnt_bot_i | input | 1 | Counter is at BOTTOM this cycle |
| mode_i | input | 2 | 0 normal, 1 clear on match, 2 single-slope PWM, 3 dual-slope PWM |
| commit_at_top_i | input | 1 | Shadow commit point: 0 at BOTTOM, 1 at TOP |
| bus_addr_i | input | 3 | 0 counter low, 1 counter high, 2 compare low, 3 compare high, 4 control |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| irq_ack_i | input | 1 | Interrupt serviced; clears the flag |
| cmp_o | output | 16 | Active compare value |
| flag_o | output | 1 | Match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the collision between the shared latch and the buffered path. In that case a counter low-byte read silently replaces a high byte that software staged for the compare register, and the commit strobes must then move exactly the mixed value. The stimulus stages a high byte, reads the counter in between, writes the low byte, and only then pulses the wrong strobe followed by the right one. The flag's priority rule is reached by holding the counter equal to the compare value while a clear is written or an acknowledge is pulsed.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    OCM_NORMAL = 2'd0,
    OCM_CLEAR  = 2'd1,
    OCM_FAST   = 2'd2,
    OCM_DUAL   = 2'd3
  } oc_mode_e;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;

  function automatic logic mode_buffered(input oc_mode_e m);
    return (m == OCM_FAST) || (m == OCM_DUAL);
  endfunction
endpackage

// File: rtl/oc_hi_latch.sv
module oc_hi_latch #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_wr,
  input  logic          ld_rd,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] cnt_hi,
  output logic [BW-1:0] hold_q
);
  logic          hold_en;
  logic [BW-1:0] hold_d;

  always_comb begin
    hold_en = ld_wr | ld_rd;
    hold_d  = ld_wr ? wdata : cnt_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end
endmodule

// File: rtl/oc_cmp_regs.sv
module oc_cmp_regs #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic [CW-1:0] wval,
  input  logic          dbuf_en,
  input  logic          commit,
  output logic [CW-1:0] shadow_q,
  output logic [CW-1:0] active_q
);
  logic          sh_en, act_en;
  logic [CW-1:0] act_d;

  always_comb begin
    sh_en  = wr_lo;
    act_en = 1'b0;
    act_d  = active_q;
    if (dbuf_en) begin
      if (commit) begin
        act_en = 1'b1;
        act_d  = shadow_q;
      end
    end else if (wr_lo) begin
      act_en = 1'b1;
      act_d  = wval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shadow_q <= '0;
    else if (sh_en) shadow_q <= wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active_q <= '0;
    else if (act_en) active_q <= act_d;
  end
endmodule

// File: rtl/oc_match_flag.sv
module oc_match_flag #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] active,
  input  logic          clr_req,
  input  logic          ack,
  input  logic          ien_wr,
  input  logic          ien_val,
  output logic          flag_q,
  output logic          ien_q,
  output logic          irq
);
  logic hit, flag_d;

  always_comb begin
    hit = (cnt == active);
    if (hit)                 flag_d = 1'b1;
    else if (clr_req || ack) flag_d = 1'b0;
    else                     flag_d = flag_q;
    irq = flag_q & ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= 1'b0;
    else if (ien_wr) ien_q <= ien_val;
  end
endmodule

// File: rtl/oc_compare_unit.sv
module oc_compare_unit
  import oc_pkg::*;
#(
  parameter int BW = 8,
  parameter int CW = 2 * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     cnt_i,
  input  logic              cnt_top_i,
  input  logic              cnt_bot_i,
  input  logic [1:0]        mode_i,
  input  logic              commit_at_top_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BW-1:0]     bus_wdata_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  output logic [BW-1:0]     bus_rdata_o,
  input  logic              irq_ack_i,
  output logic [CW-1:0]     cmp_o,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int HI = CW - BW;

  oc_mode_e      mode;
  logic          dbuf_en, commit;
  logic          wr_hi, rd_cnt_lo, wr_cmp_lo, wr_ctrl;
  logic [BW-1:0] hold_q;
  logic [CW-1:0] shadow_q, active_q;
  logic          flag_q, ien_q, irq_w;

  always_comb begin
    mode      = oc_mode_e'(mode_i);
    dbuf_en   = mode_buffered(mode);
    commit    = commit_at_top_i ? cnt_top_i : cnt_bot_i;
    wr_hi     = bus_wr_i && (bus_addr_i == A_CNT_HI || bus_addr_i == A_CMP_HI);
    rd_cnt_lo = bus_rd_i && (bus_addr_i == A_CNT_LO);
    wr_cmp_lo = bus_wr_i && (bus_addr_i == A_CMP_LO);
    wr_ctrl   = bus_wr_i && (bus_addr_i == A_CTRL);
  end

  oc_hi_latch #(.BW(BW)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_wr  (wr_hi),
    .ld_rd  (rd_cnt_lo),
    .wdata  (bus_wdata_i),
    .cnt_hi (cnt_i[CW-1:HI]),
    .hold_q (hold_q)
  );

  oc_cmp_regs #(.CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_cmp_lo),
    .wval     ({hold_q, bus_wdata_i}),
    .dbuf_en  (dbuf_en),
    .commit   (commit),
    .shadow_q (shadow_q),
    .active_q (active_q)
  );

  oc_match_flag #(.CW(CW)) u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_i),
    .active  (active_q),
    .clr_req (wr_ctrl & bus_wdata_i[0]),
    .ack     (irq_ack_i),
    .ien_wr  (wr_ctrl),
    .ien_val (bus_wdata_i[1]),
    .flag_q  (flag_q),
    .ien_q   (ien_q),
    .irq     (irq_w)
  );

  always_comb begin
    case (bus_addr_i)
      A_CNT_LO: bus_rdata_o = cnt_i[BW-1:0];
      A_CNT_HI: bus_rdata_o = hold_q;
      A_CMP_LO: bus_rdata_o = shadow_q[BW-1:0];
      A_CMP_HI: bus_rdata_o = shadow_q[CW-1:HI];
      A_CTRL:   bus_rdata_o = {{(BW-2){1'b0}}, ien_q, flag_q};
      default:  bus_rdata_o = '0;
    endcase
    cmp_o  = active_q;
    flag_o = flag_q;
    irq_o  = irq_w;
  end
endmodule

// File: rtl/oc_compare_chk.sv
module oc_compare_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt_i,
  input logic          cnt_top_i,
  input logic          cnt_bot_i,
  input logic [1:0]    mode_i,
  input logic          commit_at_top_i,
  input logic [2:0]    bus_addr_i,
  input logic          bus_wr_i,
  input logic          irq_ack_i,
  input logic [CW-1:0] cmp_o,
  input logic          flag_o,
  input logic          irq_o
);
  logic sel_strobe;
  assign sel_strobe = commit_at_top_i ? cnt_top_i : cnt_bot_i;

  // R1
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == cmp_o) |=> flag_o);

  // R3
  ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && cnt_i != cmp_o) |=> !flag_o);

  // R4
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_o |-> !irq_o);

  // R7
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[1] && !sel_strobe) |=> $stable(cmp_o));

  // R6
  direct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i[1] && !(bus_wr_i && bus_addr_i == 3'd2)) |=> $stable(cmp_o));
endmodule

bind oc_compare_unit oc_compare_chk #(.CW(CW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cnt_i           (cnt_i),
  .cnt_top_i       (cnt_top_i),
  .cnt_bot_i       (cnt_bot_i),
  .mode_i          (mode_i),
  .commit_at_top_i (commit_at_top_i),
  .bus_addr_i      (bus_addr_i),
  .bus_wr_i        (bus_wr_i),
  .irq_ack_i       (irq_ack_i),
  .cmp_o           (cmp_o),
  .flag_o          (flag_o),
  .irq_o           (irq_o)
);

// File: tb/oc_compare_unit_bench.sv
`timescale 1ns/1ps
module oc_compare_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = 16'h1234;
  logic        cnt_top_i = 1'b0, cnt_bot_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        commit_at_top_i = 1'b0;
  logic [2:0]  bus_addr_i = 3'd0;
  logic [7:0]  bus_wdata_i = 8'h00;
  logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0, irq_ack_i = 1'b0;
  logic [7:0]  bus_rdata_o;
  logic [15:0] cmp_o;
  logic        flag_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  oc_compare_unit u_oc_compare_unit (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #0.5 d = bus_rdata_o;
    @(negedge clk);
    bus_rd_i = 1'b0;
  endtask

  task automatic pulse_top();
    @(negedge clk); cnt_top_i = 1'b1;
    @(negedge clk); cnt_top_i = 1'b0;
  endtask

  task automatic pulse_bot();
    @(negedge clk); cnt_bot_i = 1'b1;
    @(negedge clk); cnt_bot_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 flag", {15'd0, flag_o}, 16'd0);
    chk("R11 irq", {15'd0, irq_o}, 16'd0);
    chk("R11 cmp", cmp_o, 16'h0000);
    rd(3'd4, d); chk("R11 ctrl", {8'd0, d}, 16'd0);
    rd(3'd1, d); chk("R11 latch", {8'd0, d}, 16'd0);
    rd(3'd2, d); chk("R11 shadow", {8'd0, d}, 16'd0);
  endtask

  task automatic t_direct();
    logic [7:0] d;
    mode_i = 2'd0;
    wr(3'd3, 8'hAB);
    chk("R5 hi write leaves cmp", cmp_o, 16'h0000);
    rd(3'd3, d); chk("R5 hi write leaves shadow", {8'd0, d}, 16'h0000);
    wr(3'd2, 8'hCD);
    chk("R6 direct write", cmp_o, 16'hABCD);
    rd(3'd2, d); chk("R12 read lo", {8'd0, d}, 16'h00CD);
    rd(3'd3, d); chk("R12 read hi", {8'd0, d}, 16'h00AB);
    mode_i = 2'd1;
    wr(3'd3, 8'h0F); wr(3'd2, 8'h0E);
    chk("R6 clear-on-match mode write", cmp_o, 16'h0F0E);
    wr(3'd3, 8'hAB); wr(3'd2, 8'hCD);
    mode_i = 2'd0;
  endtask

  task automatic t_flag();
    @(negedge clk); cnt_i = 16'hABCD;
    chk("R1 flag not yet", {15'd0, flag_o}, 16'd0);
    @(negedge clk); cnt_i = 16'h1234;
    chk("R1 flag set", {15'd0, flag_o}, 16'd1);
    chk("R4 irq off while disabled", {15'd0, irq_o}, 16'd0);
    wr(3'd4, 8'h02);
    chk("R2 write zero keeps flag", {15'd0, flag_o}, 16'd1);
    chk("R4 irq on", {15'd0, irq_o}, 16'd1);
    wr(3'd4, 8'h03);
    chk("R2 clear", {15'd0, flag_o}, 16'd0);
    chk("R4 irq follows flag", {15'd0, irq_o}, 16'd0);
    @(negedge clk); cnt_i = 16'hABCD;
    @(negedge clk);
    wr(3'd4, 8'h03);
    chk("R2 match beats clear", {15'd0, flag_o}, 16'd1);
    @(negedge clk); irq_ack_i = 1'b1;
    @(negedge clk); irq_ack_i = 1'b0;
    chk("R3 ack during match keeps flag", {15'd0, flag_o}, 16'd1);
    cnt_i = 16'h1234;
    @(negedge clk); irq_ack_i = 1'b1;
    @(negedge clk); irq_ack_i = 1'b0;
    chk("R3 ack clears", {15'd0, flag_o}, 16'd0);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_pwm_bottom();
    logic [7:0] d;
    mode_i = 2'd2; commit_at_top_i = 1'b0;
    wr(3'd3, 8'h11); wr(3'd2, 8'h22);
    chk("R7 buffered write holds cmp", cmp_o, 16'hABCD);
    rd(3'd2, d); chk("R12 shadow lo", {8'd0, d}, 16'h0022);
    pulse_top();
    chk("R8 top ignored when bottom selected", cmp_o, 16'hABCD);
    pulse_bot();
    chk("R8 bottom commit", cmp_o, 16'h1122);
  endtask

  task automatic t_pwm_top();
    mode_i = 2'd3; commit_at_top_i = 1'b1;
    wr(3'd3, 8'h33); wr(3'd2, 8'h44);
    chk("R7 dual-slope write holds cmp", cmp_o, 16'h1122);
    pulse_bot();
    chk("R8 bottom ignored when top selected", cmp_o, 16'h1122);
    pulse_top();
    chk("R8 top commit", cmp_o, 16'h3344);
  endtask

  task automatic t_latch();
    logic [7:0] d;
    mode_i = 2'd0;
    @(negedge clk); cnt_i = 16'h5A6B;
    rd(3'd0, d); chk("R9 counter lo", {8'd0, d}, 16'h006B);
    @(negedge clk); cnt_i = 16'h0001;
    rd(3'd1, d); chk("R9 snapshot hi", {8'd0, d}, 16'h005A);
    wr(3'd2, 8'h77);
    chk("R10 write uses counter snapshot", cmp_o, 16'h5A77);
    wr(3'd1, 8'h99); wr(3'd2, 8'h01);
    chk("R10 hi via counter address", cmp_o, 16'h9901);
    mode_i = 2'd2; commit_at_top_i = 1'b0;
    wr(3'd3, 8'hC3);
    @(negedge clk); cnt_i = 16'h7E00;
    rd(3'd0, d);
    @(negedge clk); cnt_i = 16'h1234;
    wr(3'd2, 8'h3C);
    pulse_top();
    chk("R10 buffered: wrong strobe", cmp_o, 16'h9901);
    pulse_bot();
    chk("R10 buffered: snapshot overrides staged hi", cmp_o, 16'h7E3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_flag();
    t_pwm_bottom();
    t_pwm_top();
    t_latch();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule